// File: doc/BRIEF.md
# SCL Stuck-Low Timeout Watchdog

This block watches the clock line of a two-wire serial bus and decides when a device has held it LOW for too long. Software programs an 8-bit timeout register: the top bit arms the watchdog and the lower seven bits set a window length. While the bus interface reports that it is active, a down-counter is reloaded from the register whenever the synchronised clock line changes level. The counter then steps down once per prescaler period while the line stays LOW. With the default prescaler of 4096 oscillator cycles at a nominal 35 ns, each step is roughly 143 microseconds.

If the line is still LOW when the counter runs out, the block declares a bus error. It reports the fixed status code 78h, raises its interrupt, and drives both release outputs so that the bus controller lets go of the clock and data lines. The error stays latched until the block is reset. A counter reload also happens when activity begins. A controller that wants to issue a START while another device already holds the clock LOW therefore waits one full window before the error is declared.

Top module: `scl_lowtime_watchdog`

## Requirements
- R1: After reset, status reads 00h, irq is 0, both release outputs are 0 and the timeout register reads 00h.
- R2: A write on the register port stores all 8 bits, and the stored byte appears on reg_rdata from the next cycle. Bit 7 is the enable (1 = armed) and bits 6:0 are the window value V.
- R3: The scl input passes through two synchronising flip-flops, and a reload is taken on the third clock edge after the input changes. Counting from the edge at which a reload happens, the error becomes visible exactly (V+1)×PRESC clock edges later, provided the line stays LOW.
- R4: While enabled and active, every level change of the synchronised line reloads the counter and clears the prescaler. A line that keeps toggling with LOW phases shorter than the window never raises an error.
- R5: On a bus error, status reads 78h, irq is 1, and scl_release and sda_release are both 1.
- R6: While bit 7 of the timeout register is 0, the counter is held and no error is raised, however long the line stays LOW.
- R7: While bus_active is 0, no counting and no reload take place, and no error is raised.
- R8: When bus_active rises, the counter reloads on the next edge even if the line is already LOW, so the error follows after (V+1)×PRESC edges.
- R9: Once raised, the error, the status code, irq and both release outputs stay set until rst_n is asserted, whatever scl and bus_active do.
- R10: While the synchronised line is HIGH, the counter does not step and no error is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the timeout register |
| reg_wdata | input | 8 | Write data: bit 7 enable, bits 6:0 window value |
| reg_rdata | output | 8 | Current timeout register contents |
| scl_in | input | 1 | Raw clock line level from the bus pad |
| bus_active | input | 1 | High while the bus interface is operating |
| irq | output | 1 | Interrupt, high while a bus error is latched |
| status | output | 8 | 00h normally, 78h after a bus error |
| scl_release | output | 1 | Forces the clock line driver to release |
| sda_release | output | 1 | Forces the data line driver to release |

## Verification
The bench builds the block with PRESC set to 4, so that one counter step takes four clocks. This puts the exact expiry edge of small windows (V = 0, 1, 3) within a few dozen cycles, and each is probed one edge before and one edge at expiry. The same setting lets the largest window (V = 127) be shown not to fire early. Toggling patterns, the activity-start reload and the latched state after an error are then checked at cycle precision without long runs.

// File: rtl/scl_wd_pkg.sv
package scl_wd_pkg;
    localparam int TO_REG_W   = 8;
    localparam int TO_VAL_W   = TO_REG_W - 1;
    localparam int STAT_W     = 8;
    localparam logic [STAT_W-1:0] BUS_ERR_CODE = 8'h78;
    localparam logic [STAT_W-1:0] IDLE_CODE    = 8'h00;

    typedef struct packed {
        logic                en;
        logic [TO_VAL_W-1:0] val;
    } to_reg_t;

    typedef struct packed {
        logic [TO_VAL_W-1:0] cnt;
        logic                err;
        logic                act_prev;
    } core_state_t;

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_state_t;
endpackage

// File: rtl/scl_wd_sync.sv
module scl_wd_sync
    import scl_wd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    output logic scl_low,
    output logic scl_edge
);
    sync_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = scl_raw;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: 1'b1, s2: 1'b1, prev: 1'b1};
        else        st_q <= st_d;
    end

    assign scl_low  = ~st_q.s2;
    assign scl_edge = st_q.s2 ^ st_q.prev;

    // R3: a change on the synchronised level must come from the first stage
    a_r3_sync_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s2 != $past(st_q.s2)) |-> (st_q.s2 == $past(st_q.s1)));
endmodule

// File: rtl/scl_wd_prescale.sv
module scl_wd_prescale #(
    parameter int PRESC = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESC - 1);

    logic [PW-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        if (clr)
            pre_d = '0;
        else if (run)
            pre_d = (pre_q == LAST) ? '0 : pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign tick = run && !clr && (pre_q == LAST);

    a_r4_clear_on_reload: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pre_q == '0));
    a_r3_pre_range: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= LAST);
endmodule

// File: rtl/scl_wd_core.sv
module scl_wd_core
    import scl_wd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  to_reg_t             cfg,
    input  logic                bus_active,
    input  logic                scl_low,
    input  logic                scl_edge,
    input  logic                tick,
    output logic                reload,
    output logic                count_en,
    output logic                err
);
    core_state_t st_d, st_q;

    always_comb begin
        reload   = cfg.en && bus_active && !st_q.err && (scl_edge || !st_q.act_prev);
        count_en = cfg.en && bus_active && scl_low && !st_q.err && !reload;

        st_d          = st_q;
        st_d.act_prev = bus_active;
        if (!st_q.err) begin
            if (reload)
                st_d.cnt = cfg.val;
            else if (count_en && tick) begin
                if (st_q.cnt == '0) st_d.err = 1'b1;
                else                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err = st_q.err;

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |=> st_q.err);
    a_r3_expiry_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.err) |-> ($past(tick) && $past(st_q.cnt) == '0 && $past(scl_low)));
    a_r4_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (st_q.cnt == $past(cfg.val)));
    a_r6_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |=> ($stable(st_q.cnt) && $stable(st_q.err)));
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_active |=> ($stable(st_q.cnt) && $stable(st_q.err)));
    a_r10_high_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_low && !reload) |=> $stable(st_q.cnt) && $stable(st_q.err));
endmodule

// File: rtl/scl_lowtime_watchdog.sv
module scl_lowtime_watchdog
    import scl_wd_pkg::*;
#(
    parameter int PRESC = 4096
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [TO_REG_W-1:0] reg_wdata,
    output logic [TO_REG_W-1:0] reg_rdata,
    input  logic                scl_in,
    input  logic                bus_active,
    output logic                irq,
    output logic [STAT_W-1:0]   status,
    output logic                scl_release,
    output logic                sda_release
);
    to_reg_t cfg_d, cfg_q;
    logic    scl_low, scl_edge, tick, reload, count_en, err;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr) cfg_d = to_reg_t'(reg_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    scl_wd_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_raw  (scl_in),
        .scl_low  (scl_low),
        .scl_edge (scl_edge)
    );

    scl_wd_prescale #(.PRESC(PRESC)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (reload),
        .run   (count_en),
        .tick  (tick)
    );

    scl_wd_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg_q),
        .bus_active (bus_active),
        .scl_low    (scl_low),
        .scl_edge   (scl_edge),
        .tick       (tick),
        .reload     (reload),
        .count_en   (count_en),
        .err        (err)
    );

    assign reg_rdata   = cfg_q;
    assign irq         = err;
    assign status      = err ? BUS_ERR_CODE : IDLE_CODE;
    assign scl_release = err;
    assign sda_release = err;

    a_r5_err_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(scl_low) && $past(cfg_q.en) && $past(bus_active));
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_rdata == $past(reg_wdata)));
endmodule

// File: tb/scl_lowtime_watchdog_tb.sv
module scl_lowtime_watchdog_tb;
    localparam int CLK_PERIOD = 10;
    localparam int P = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       scl_in = 1'b1;
    logic       bus_active = 1'b0;
    logic       irq;
    logic [7:0] status;
    logic       scl_release, sda_release;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_lowtime_watchdog #(.PRESC(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .scl_in(scl_in), .bus_active(bus_active),
        .irq(irq), .status(status), .scl_release(scl_release),
        .sda_release(sda_release)
    );

    // {reg byte, low edges, pad, expected error}; threshold is 3+(V+1)*P edges
    localparam int NV = 7;
    localparam logic [31:0] VEC [NV] = '{
        {8'h80, 16'd6,   7'd0, 1'b0},
        {8'h80, 16'd7,   7'd0, 1'b1},
        {8'h83, 16'd18,  7'd0, 1'b0},
        {8'h83, 16'd19,  7'd0, 1'b1},
        {8'h03, 16'd60,  7'd0, 1'b0},
        {8'hFF, 16'd200, 7'd0, 1'b0},
        {8'h81, 16'd11,  7'd0, 1'b1}
    };

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic err_state(string req, logic e);
        check(req, {7'd0, irq}, {7'd0, e});
        check(req, status, e ? 8'h78 : 8'h00);
        check(req, {6'd0, scl_release, sda_release}, e ? 8'h03 : 8'h00);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; scl_in = 1'b1; bus_active = 1'b0; reg_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        err_state("R1", 1'b0);
        check("R1", reg_rdata, 8'h00);

        // R2 register write and readback
        wr(8'hA5);
        check("R2", reg_rdata, 8'hA5);
        wr(8'h3C);
        check("R2", reg_rdata, 8'h3C);

        // R3 R5 R6: table of windows
        for (int i = 0; i < NV; i++) begin
            do_reset();
            wr(VEC[i][31:24]);
            bus_active = 1'b1;
            repeat (3) @(negedge clk);
            scl_in = 1'b0;
            repeat (int'(VEC[i][23:8])) @(posedge clk);
            @(negedge clk);
            err_state(VEC[i][31] ? "R3/R5 table" : "R6 table", VEC[i][0]);
        end

        // R9 sticky after error (last vector left error set)
        scl_in = 1'b1; bus_active = 1'b0;
        repeat (10) @(negedge clk);
        err_state("R9 sticky", 1'b1);
        do_reset();
        err_state("R9 cleared by reset", 1'b0);

        // R4 toggling with short low phases, V=1 window is 11 edges
        wr(8'h81);
        bus_active = 1'b1;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 10; k++) begin
            scl_in = 1'b0;
            repeat (8) @(negedge clk);
            scl_in = 1'b1;
            repeat (3) @(negedge clk);
        end
        err_state("R4 reload on toggle", 1'b0);

        // R10 line held high for long
        repeat (100) @(negedge clk);
        err_state("R10 high no count", 1'b0);

        // R7 inactive bus with line low
        do_reset();
        wr(8'h81);
        scl_in = 1'b0;
        repeat (80) @(negedge clk);
        err_state("R7 inactive", 1'b0);

        // R8 activity begins while line already low: error at edge 1+(V+1)*P = 9
        bus_active = 1'b1;
        repeat (8) @(posedge clk);
        @(negedge clk);
        err_state("R8 before expiry", 1'b0);
        @(posedge clk);
        @(negedge clk);
        err_state("R8 at expiry", 1'b1);

        // R6 disabling mid-window holds counter
        do_reset();
        wr(8'h81);
        bus_active = 1'b1;
        repeat (3) @(negedge clk);
        scl_in = 1'b0;
        repeat (6) @(negedge clk);
        wr(8'h01);
        repeat (60) @(negedge clk);
        err_state("R6 disabled hold", 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule